// File: doc/BRIEF.md
# Transfer-Controller Activation and Interrupt Router

This block sits between a set of peripheral interrupt sources and two consumers: a data-transfer engine and the CPU interrupt controller. Each source has an activation flag, set by a one-cycle pulse from its peripheral, and a routing enable bit. A set flag with the enable at 1 is an activation request for the transfer engine. A set flag with the enable at 0 is a level interrupt request to the CPU. Software can also request a transfer. It writes a trigger word that holds an enable bit and a vector number.

Pending activations are ranked by a fixed priority. The lowest source index ranks highest, and the software trigger ranks below every hardware source. Only one activation is outstanding at a time. The winner is offered to the engine as a held start request that carries a vector index, until the engine acknowledges it. The engine later reports completion together with three status bits: count ended, disable-on-interrupt and last-of-chain.

On the last completion of a chain, the block takes one of two paths:
- The clear path is taken when disable-on-interrupt is 0 and the count has not ended. It clears the source flag and keeps the routing enable. For the software trigger, it clears the trigger enable.
- The keep path is taken otherwise. It keeps the flag and clears the routing enable, so the source now shows as a CPU interrupt. For the software trigger, it keeps the trigger enable and raises a software interrupt line.

Top module: `xfer_act_router`

## Requirements
- R1: After reset, start_req, every cpu_irq bit and cpu_sw_irq are 0, and all routing enables are 0.
- R2: A source pulse sets that source's flag at the next edge. If the source's enable bit (bit i of the last en_wdata written with en_wr) is 0, cpu_irq[i] is 1 from that edge onward. If the enable bit is 1, cpu_irq[i] stays 0 and a start request with start_vec = i and start_is_sw = 0 follows.
- R3: Among pending activations, the lowest hardware index is granted first. The software trigger is granted only when no hardware activation is pending.
- R4: start_req stays high with stable start_vec and start_is_sw until start_ack is sampled high. It then drops, and no new start_req appears until a completion with chain_last = 1.
- R5: Clear path (disel = 0 and count_ended = 0) for a hardware source: the flag is cleared, the enable stays 1, and no CPU interrupt is raised.
- R6: Keep path (disel = 1 or count_ended = 1) for a hardware source: the enable is cleared and the flag stays set, so cpu_irq[i] becomes 1 and the source no longer requests transfers.
- R7: A write with sw_wr and sw_wr_en = 1 arms the software trigger and stores sw_wr_vec. The resulting start request has start_is_sw = 1 and start_vec equal to the stored vector.
- R8: On the software clear path the trigger is disarmed and cpu_sw_irq stays 0. On the software keep path the trigger stays armed and cpu_sw_irq becomes 1. While cpu_sw_irq is 1 the trigger is not granted, and sw_irq_clr removes cpu_sw_irq.
- R9: xfer_done with chain_last = 0 changes no flag or enable, and the block stays busy.
- R10: cpu_irq[i] is a level that holds until a flag_clr[i] strobe clears the flag.
- R11: A source pulse in the same cycle as that source's clear-path completion leaves the flag set, so the source is requested again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_pulse | input | NUM_SRC | One-cycle activation events from peripherals |
| flag_clr | input | NUM_SRC | CPU strobes that clear source flags |
| en_wr | input | 1 | Write strobe for the routing enable word |
| en_wdata | input | NUM_SRC | New routing enables (1 = transfer engine, 0 = CPU) |
| sw_wr | input | 1 | Write strobe for the software trigger word |
| sw_wr_en | input | 1 | Software trigger enable bit being written |
| sw_wr_vec | input | VEC_W | Software trigger vector being written |
| sw_irq_clr | input | 1 | Clears the software CPU interrupt |
| start_req | output | 1 | Start request to the transfer engine |
| start_vec | output | VEC_W | Vector index of the request |
| start_is_sw | output | 1 | Request comes from the software trigger |
| start_ack | input | 1 | Engine accepts the start request |
| xfer_done | input | 1 | Engine completion pulse |
| chain_last | input | 1 | Completion is the last of a chain |
| count_ended | input | 1 | Transfer count reached its end |
| disel | input | 1 | Disable-on-interrupt bit of the finished transfer |
| cpu_irq | output | NUM_SRC | Level interrupt requests to the CPU |
| cpu_sw_irq | output | 1 | Software-activation interrupt to the CPU |

## Verification
The hardest situation to reach is a grant order that involves many sources pending together with the software trigger, while the engine's completions arrive one at a time. The bench raises every non-zero combination of the eight source pulses in one cycle, arms the software trigger in the same cycle, and then serves each grant in turn. It expects the lowest remaining set bit first and the software vector last. A second hard case is a new peripheral pulse that lands exactly on the completion edge. The bench places that pulse inside the final done cycle of a transfer.

// File: rtl/xfer_act_pkg.sv
package xfer_act_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_REQ  = 2'd1,
    SEQ_BUSY = 2'd2
  } seq_state_e;
endpackage

// File: rtl/xfer_src_bank.sv
// Per-source activation flags and routing enables.
module xfer_src_bank #(
  parameter int NUM_SRC = 8,
  parameter int IDX_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_pulse,
  input  logic [NUM_SRC-1:0] flag_clr,
  input  logic               en_wr,
  input  logic [NUM_SRC-1:0] en_wdata,
  input  logic               upd_valid,
  input  logic               upd_keep,
  input  logic [IDX_W-1:0]   upd_idx,
  output logic [NUM_SRC-1:0] flag_o,
  output logic [NUM_SRC-1:0] en_o
);
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    logic hit;
    logic flag_d, flag_q;
    logic en_d, en_q;

    assign hit = upd_valid && (upd_idx == IDX_W'(g));

    // new events win over any clearing in the same cycle
    always_comb begin
      flag_d = flag_q;
      if (src_pulse[g])           flag_d = 1'b1;
      else if (flag_clr[g])       flag_d = 1'b0;
      else if (hit && !upd_keep)  flag_d = 1'b0;
    end

    // a software write of the enable word wins over completion
    always_comb begin
      en_d = en_q;
      if (en_wr)                 en_d = en_wdata[g];
      else if (hit && upd_keep)  en_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag_q <= 1'b0;
        en_q   <= 1'b0;
      end else begin
        flag_q <= flag_d;
        en_q   <= en_d;
      end
    end

    assign flag_o[g] = flag_q;
    assign en_o[g]   = en_q;
  end
endmodule

// File: rtl/xfer_prio_arb.sv
// Fixed priority: index 0 highest, software request lowest.
module xfer_prio_arb #(
  parameter int NUM_SRC = 8,
  parameter int IDX_W   = 3
) (
  input  logic [NUM_SRC-1:0] hw_req,
  input  logic               sw_req,
  output logic               gnt_valid,
  output logic               gnt_sw,
  output logic [IDX_W-1:0]   gnt_idx
);
  logic [NUM_SRC:0]   seen;
  logic [NUM_SRC-1:0] onehot;

  assign seen[0] = 1'b0;
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_chain
    assign onehot[g]  = hw_req[g] & ~seen[g];
    assign seen[g+1]  = seen[g] | hw_req[g];
  end

  always_comb begin
    gnt_idx = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (onehot[i]) gnt_idx = IDX_W'(i);
    end
  end

  assign gnt_valid = seen[NUM_SRC] | sw_req;
  assign gnt_sw    = ~seen[NUM_SRC] & sw_req;
endmodule

// File: rtl/xfer_act_seq.sv
// One-outstanding activation sequencer: idle -> request -> busy.
module xfer_act_seq
  import xfer_act_pkg::*;
#(
  parameter int IDX_W = 3,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gnt_valid,
  input  logic             gnt_sw,
  input  logic [IDX_W-1:0] gnt_idx,
  input  logic [VEC_W-1:0] gnt_vec,
  input  logic             start_ack,
  input  logic             xfer_done,
  input  logic             chain_last,
  input  logic             count_ended,
  input  logic             disel,
  output logic             req_o,
  output logic [VEC_W-1:0] vec_o,
  output logic             sw_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             cmpl_valid_o,
  output logic             cmpl_keep_o
);
  seq_state_e       state_d, state_q;
  logic             load;
  logic [VEC_W-1:0] vec_q;
  logic [IDX_W-1:0] idx_q;
  logic             sw_q;

  always_comb begin
    state_d = state_q;
    load    = 1'b0;
    case (state_q)
      SEQ_IDLE: if (gnt_valid) begin
        state_d = SEQ_REQ;
        load    = 1'b1;
      end
      SEQ_REQ:  if (start_ack) state_d = SEQ_BUSY;
      SEQ_BUSY: if (xfer_done && chain_last) state_d = SEQ_IDLE;
      default:  state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEQ_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q <= '0;
      idx_q <= '0;
      sw_q  <= 1'b0;
    end else if (load) begin
      vec_q <= gnt_vec;
      idx_q <= gnt_idx;
      sw_q  <= gnt_sw;
    end
  end

  assign req_o        = (state_q == SEQ_REQ);
  assign vec_o        = vec_q;
  assign sw_o         = sw_q;
  assign idx_o        = idx_q;
  assign cmpl_valid_o = (state_q == SEQ_BUSY) && xfer_done && chain_last;
  assign cmpl_keep_o  = disel | count_ended;
endmodule

// File: rtl/xfer_act_router.sv
module xfer_act_router #(
  parameter int NUM_SRC = 8,
  parameter int VEC_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_pulse,
  input  logic [NUM_SRC-1:0] flag_clr,
  input  logic               en_wr,
  input  logic [NUM_SRC-1:0] en_wdata,
  input  logic               sw_wr,
  input  logic               sw_wr_en,
  input  logic [VEC_W-1:0]   sw_wr_vec,
  input  logic               sw_irq_clr,
  output logic               start_req,
  output logic [VEC_W-1:0]   start_vec,
  output logic               start_is_sw,
  input  logic               start_ack,
  input  logic               xfer_done,
  input  logic               chain_last,
  input  logic               count_ended,
  input  logic               disel,
  output logic [NUM_SRC-1:0] cpu_irq,
  output logic               cpu_sw_irq
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [NUM_SRC-1:0] flag_w, en_w, hw_req_w;
  logic               gnt_valid_w, gnt_sw_w;
  logic [IDX_W-1:0]   gnt_idx_w, cmpl_idx_w;
  logic [VEC_W-1:0]   gnt_vec_w;
  logic               cmpl_valid_w, cmpl_keep_w, cmpl_sw_w;
  logic               hw_cmpl_w, sw_cmpl_w;
  logic               sw_en_d, sw_en_q, sw_irq_d, sw_irq_q, sw_req_w;
  logic [VEC_W-1:0]   sw_vec_q;

  assign hw_cmpl_w = cmpl_valid_w & ~cmpl_sw_w;
  assign sw_cmpl_w = cmpl_valid_w &  cmpl_sw_w;

  xfer_src_bank #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) bank_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_pulse (src_pulse),
    .flag_clr  (flag_clr),
    .en_wr     (en_wr),
    .en_wdata  (en_wdata),
    .upd_valid (hw_cmpl_w),
    .upd_keep  (cmpl_keep_w),
    .upd_idx   (cmpl_idx_w),
    .flag_o    (flag_w),
    .en_o      (en_w)
  );

  // software trigger: arm/disarm by write, completion disarms on clear path
  always_comb begin
    sw_en_d = sw_en_q;
    if (sw_wr)                          sw_en_d = sw_wr_en;
    else if (sw_cmpl_w && !cmpl_keep_w) sw_en_d = 1'b0;
  end

  always_comb begin
    sw_irq_d = sw_irq_q;
    if (sw_cmpl_w && cmpl_keep_w) sw_irq_d = 1'b1;
    else if (sw_irq_clr)          sw_irq_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_en_q  <= 1'b0;
      sw_irq_q <= 1'b0;
    end else begin
      sw_en_q  <= sw_en_d;
      sw_irq_q <= sw_irq_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sw_vec_q <= '0;
    else if (sw_wr) sw_vec_q <= sw_wr_vec;
  end

  assign hw_req_w = flag_w & en_w;
  assign sw_req_w = sw_en_q & ~sw_irq_q;

  xfer_prio_arb #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) arb_i (
    .hw_req    (hw_req_w),
    .sw_req    (sw_req_w),
    .gnt_valid (gnt_valid_w),
    .gnt_sw    (gnt_sw_w),
    .gnt_idx   (gnt_idx_w)
  );

  assign gnt_vec_w = gnt_sw_w ? sw_vec_q : VEC_W'(gnt_idx_w);

  xfer_act_seq #(.IDX_W(IDX_W), .VEC_W(VEC_W)) seq_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .gnt_valid    (gnt_valid_w),
    .gnt_sw       (gnt_sw_w),
    .gnt_idx      (gnt_idx_w),
    .gnt_vec      (gnt_vec_w),
    .start_ack    (start_ack),
    .xfer_done    (xfer_done),
    .chain_last   (chain_last),
    .count_ended  (count_ended),
    .disel        (disel),
    .req_o        (start_req),
    .vec_o        (start_vec),
    .sw_o         (cmpl_sw_w),
    .idx_o        (cmpl_idx_w),
    .cmpl_valid_o (cmpl_valid_w),
    .cmpl_keep_o  (cmpl_keep_w)
  );

  assign start_is_sw = cmpl_sw_w;
  assign cpu_irq     = flag_w & ~en_w;
  assign cpu_sw_irq  = sw_irq_q;
endmodule

// File: rtl/xfer_act_router_chk.sv
module xfer_act_router_chk #(
  parameter int NUM_SRC = 8,
  parameter int VEC_W   = 8,
  parameter int IDX_W   = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start_req,
  input logic               start_ack,
  input logic [VEC_W-1:0]   start_vec,
  input logic               start_is_sw,
  input logic [NUM_SRC-1:0] cpu_irq,
  input logic               cpu_sw_irq,
  input logic [NUM_SRC-1:0] src_pulse,
  input logic [NUM_SRC-1:0] flag_clr,
  input logic               en_wr,
  input logic               sw_wr,
  input logic [NUM_SRC-1:0] flag_w,
  input logic [NUM_SRC-1:0] hw_req_w,
  input logic               cmpl_valid_w,
  input logic               cmpl_keep_w,
  input logic               cmpl_sw_w,
  input logic [IDX_W-1:0]   cmpl_idx_w,
  input logic               sw_en_q
);
  assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start_req && !start_ack |=> start_req && $stable(start_vec) && $stable(start_is_sw));

  assert_one_outstanding_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start_req && start_ack |=> !start_req);

  assert_sw_lowest_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(start_req) && start_is_sw |-> $past(hw_req_w) == '0);

  assert_clear_path_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmpl_valid_w && !cmpl_sw_w && !cmpl_keep_w && !src_pulse[cmpl_idx_w]
    |=> !flag_w[$past(cmpl_idx_w)]);

  assert_keep_path_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmpl_valid_w && !cmpl_sw_w && cmpl_keep_w && !en_wr
    && flag_w[cmpl_idx_w] && !flag_clr[cmpl_idx_w]
    |=> cpu_irq[$past(cmpl_idx_w)]);

  assert_sw_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmpl_valid_w && cmpl_sw_w && !cmpl_keep_w && !sw_wr |=> !sw_en_q);

  assert_sw_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmpl_valid_w && cmpl_sw_w && cmpl_keep_w |=> cpu_sw_irq);
endmodule

bind xfer_act_router xfer_act_router_chk #(
  .NUM_SRC(NUM_SRC), .VEC_W(VEC_W), .IDX_W(IDX_W)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_req    (start_req),
  .start_ack    (start_ack),
  .start_vec    (start_vec),
  .start_is_sw  (start_is_sw),
  .cpu_irq      (cpu_irq),
  .cpu_sw_irq   (cpu_sw_irq),
  .src_pulse    (src_pulse),
  .flag_clr     (flag_clr),
  .en_wr        (en_wr),
  .sw_wr        (sw_wr),
  .flag_w       (flag_w),
  .hw_req_w     (hw_req_w),
  .cmpl_valid_w (cmpl_valid_w),
  .cmpl_keep_w  (cmpl_keep_w),
  .cmpl_sw_w    (cmpl_sw_w),
  .cmpl_idx_w   (cmpl_idx_w),
  .sw_en_q      (sw_en_q)
);

// File: tb/xfer_act_router_tb_top.sv
`timescale 1ns/1ps
module xfer_act_router_tb_top;
  localparam int N  = 8;
  localparam int VW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  src_pulse, flag_clr, en_wdata;
  logic          en_wr, sw_wr, sw_wr_en, sw_irq_clr;
  logic [VW-1:0] sw_wr_vec;
  logic          start_req, start_is_sw, start_ack;
  logic [VW-1:0] start_vec;
  logic          xfer_done, chain_last, count_ended, disel;
  logic [N-1:0]  cpu_irq;
  logic          cpu_sw_irq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  xfer_act_router #(.NUM_SRC(N), .VEC_W(VW)) dut_i (
    .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse), .flag_clr(flag_clr),
    .en_wr(en_wr), .en_wdata(en_wdata), .sw_wr(sw_wr), .sw_wr_en(sw_wr_en),
    .sw_wr_vec(sw_wr_vec), .sw_irq_clr(sw_irq_clr), .start_req(start_req),
    .start_vec(start_vec), .start_is_sw(start_is_sw), .start_ack(start_ack),
    .xfer_done(xfer_done), .chain_last(chain_last), .count_ended(count_ended),
    .disel(disel), .cpu_irq(cpu_irq), .cpu_sw_irq(cpu_sw_irq)
  );

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_en(input logic [N-1:0] m);
    en_wr = 1'b1; en_wdata = m; cyc(); en_wr = 1'b0;
  endtask

  task automatic pulse(input logic [N-1:0] m);
    src_pulse = m; cyc(); src_pulse = '0;
  endtask

  task automatic clr_flag(input logic [N-1:0] m);
    flag_clr = m; cyc(); flag_clr = '0;
  endtask

  task automatic no_req(input int n, input string tag);
    for (int k = 0; k < n; k++) begin
      cyc();
      chk(!start_req, tag, start_req, 0);
    end
  endtask

  // serve one activation; repulse >= 0 pulses that source on the final done cycle
  task automatic serve(input int exp_vec, input bit exp_sw, input bit dis,
                       input bit ce, input int repulse, input string tag);
    for (int k = 0; k < 10; k++) if (!start_req) cyc();
    chk(start_req, {tag, " start_req"}, start_req, 1);
    chk(start_vec == VW'(exp_vec), {tag, " start_vec"}, start_vec, exp_vec);
    chk(start_is_sw == exp_sw, {tag, " start_is_sw"}, start_is_sw, exp_sw);
    cyc();
    chk(start_req && start_vec == VW'(exp_vec), "R4 held without ack", start_req, 1);
    start_ack = 1'b1; cyc(); start_ack = 1'b0;
    chk(!start_req, "R4 drop after ack", start_req, 0);
    xfer_done = 1'b1; chain_last = 1'b0; cyc(); xfer_done = 1'b0;
    cyc();
    chk(!start_req, "R9 mid-chain done keeps busy", start_req, 0);
    xfer_done = 1'b1; chain_last = 1'b1; disel = dis; count_ended = ce;
    if (repulse >= 0) src_pulse = N'(1) << repulse;
    cyc();
    xfer_done = 1'b0; chain_last = 1'b0; disel = 1'b0; count_ended = 1'b0;
    src_pulse = '0;
  endtask

  initial begin
    rst_n = 1'b0;
    src_pulse = '0; flag_clr = '0; en_wr = 1'b0; en_wdata = '0;
    sw_wr = 1'b0; sw_wr_en = 1'b0; sw_wr_vec = '0; sw_irq_clr = 1'b0;
    start_ack = 1'b0; xfer_done = 1'b0; chain_last = 1'b0;
    count_ended = 1'b0; disel = 1'b0;
    repeat (3) cyc();
    chk(!start_req && cpu_irq == '0 && !cpu_sw_irq, "R1 in reset", start_req, 0);
    rst_n = 1'b1;
    cyc();
    chk(!start_req, "R1 start_req after reset", start_req, 0);
    chk(cpu_irq == '0, "R1 cpu_irq after reset", cpu_irq, 0);
    chk(!cpu_sw_irq, "R1 cpu_sw_irq after reset", cpu_sw_irq, 0);
    // enables are 0 after reset: a pulse goes to the CPU
    pulse(8'h10);
    chk(cpu_irq == 8'h10, "R1 R2 reset enables route to CPU", cpu_irq, 8'h10);
    no_req(3, "R2 CPU-routed source starts nothing");
    chk(cpu_irq == 8'h10, "R10 level held", cpu_irq, 8'h10);
    clr_flag(8'h10);
    chk(cpu_irq == '0, "R10 cleared by strobe", cpu_irq, 0);

    // every source with every completion status
    for (int s = 0; s < N; s++) begin
      for (int m = 0; m < 4; m++) begin
        bit dis, ce, keep;
        dis = m[0]; ce = m[1]; keep = dis | ce;
        set_en(N'(1) << s);
        pulse(N'(1) << s);
        chk(cpu_irq == '0, "R2 routed source no cpu_irq", cpu_irq, 0);
        serve(s, 1'b0, dis, ce, -1, "R2");
        if (keep) begin
          chk(cpu_irq == (N'(1) << s), "R6 keep path raises cpu_irq", cpu_irq, 1 << s);
          no_req(3, "R6 enable cleared, no restart");
          chk(cpu_irq == (N'(1) << s), "R10 cpu_irq level held", cpu_irq, 1 << s);
          clr_flag(N'(1) << s);
          chk(cpu_irq == '0, "R10 flag_clr drops cpu_irq", cpu_irq, 0);
          pulse(N'(1) << s);
          chk(cpu_irq == (N'(1) << s), "R6 source now routed to CPU", cpu_irq, 1 << s);
          no_req(2, "R6 no transfer after enable cleared");
          clr_flag(N'(1) << s);
        end else begin
          chk(cpu_irq == '0, "R5 clear path no cpu_irq", cpu_irq, 0);
          no_req(3, "R5 flag cleared, no restart");
          pulse(N'(1) << s);
          serve(s, 1'b0, 1'b0, 1'b0, -1, "R5 enable kept");
          chk(cpu_irq == '0, "R5 second clear", cpu_irq, 0);
        end
        set_en('0);
      end
    end

    // priority sweep over all source combinations plus software trigger
    set_en('1);
    for (int mask = 1; mask < (1 << N); mask++) begin
      logic [N-1:0] rem;
      rem = N'(mask);
      src_pulse = N'(mask);
      sw_wr = 1'b1; sw_wr_en = 1'b1; sw_wr_vec = 8'hA5;
      cyc();
      src_pulse = '0; sw_wr = 1'b0; sw_wr_en = 1'b0;
      while (rem != '0) begin
        int lo;
        lo = 0;
        for (int b = N - 1; b >= 0; b--) if (rem[b]) lo = b;
        serve(lo, 1'b0, 1'b0, 1'b0, -1, "R3 lowest index first");
        rem[lo] = 1'b0;
      end
      serve(8'hA5, 1'b1, 1'b0, 1'b0, -1, "R3 R7 software last");
      chk(!cpu_sw_irq, "R8 sw clear path no irq", cpu_sw_irq, 0);
      no_req(2, "R8 sw trigger disarmed");
    end
    set_en('0);

    // software keep path
    sw_wr = 1'b1; sw_wr_en = 1'b1; sw_wr_vec = 8'h3C; cyc(); sw_wr = 1'b0; sw_wr_en = 1'b0;
    serve(8'h3C, 1'b1, 1'b1, 1'b0, -1, "R7 sw vector");
    chk(cpu_sw_irq, "R8 sw keep path raises irq", cpu_sw_irq, 1);
    no_req(4, "R8 no sw restart while irq pending");
    sw_irq_clr = 1'b1; cyc(); sw_irq_clr = 1'b0;
    chk(!cpu_sw_irq, "R8 sw_irq_clr", cpu_sw_irq, 0);
    serve(8'h3C, 1'b1, 1'b0, 1'b1, -1, "R8 trigger stayed armed");
    chk(cpu_sw_irq, "R8 count ended keeps path", cpu_sw_irq, 1);
    sw_irq_clr = 1'b1; cyc(); sw_irq_clr = 1'b0;
    serve(8'h3C, 1'b1, 1'b0, 1'b0, -1, "R8 re-served");
    chk(!cpu_sw_irq, "R8 clear path", cpu_sw_irq, 0);
    no_req(3, "R8 disarmed after clear path");

    // pulse on the completion edge
    set_en(8'h08);
    pulse(8'h08);
    serve(3, 1'b0, 1'b0, 1'b0, 3, "R11 first");
    serve(3, 1'b0, 1'b0, 1'b0, -1, "R11 re-requested");
    no_req(3, "R11 then cleared");
    set_en('0);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule